// File: doc/BRIEF.md
# Two-wire bus recovery sequencer

This block brings a two-wire serial bus back to a known idle state after a slave may have been interrupted mid-byte and left holding the data line low. On a single-cycle request it releases both lines, toggles the clock line nine times while sampling the data line after every rising clock, and remembers whether the data line was ever seen high. Nine clocks are enough to walk any slave through the rest of a byte and its acknowledge slot.

If the data line was seen high, the sequencer produces a START immediately followed by a STOP. It does this only by pulling the data line low for one microsecond and releasing it, while the clock line stays released the whole time. Because no clock edge falls between the two conditions, no slave can misread them as the start of a transfer. It then keeps the bus quiet for the bus-free time before it reports. If the data line never went high, it skips that step and reports failure. Both lines are open-drain: an `_oe` output high means "pull the line low", and the `_in` inputs read the wired level. All timing is counted in microseconds derived from the system clock by the `CLK_PER_US` parameter.

Top module: `twi_recover`

## Requirements
- R1: Out of reset and while idle, neither line is pulled low (`scl_oe`=0, `sda_oe`=0) and `busy`=0 and `done`=0.
- R2: A request produces exactly `PULSES` (default 9) clock-low phases. Clocking continues through all of them even when the data line was already seen high.
- R3: Each clock-low phase lasts `LOW_US` microseconds. After release, the line is held released for `HIGH_US` microseconds once it reads high, and the data line is sampled at the end of that time.
- R4: If the data line read high at any of the samples, `ok`=1 at completion. If it never did, `ok`=0 and no START/STOP is generated (`sda_oe` never asserts).
- R5: The recovery START/STOP waits `SETUP_US` with both lines released, then pulls the data line low for exactly `SDA_LOW_US` microseconds and releases it. The clock line is never pulled low while the data line is pulled low.
- R6: After the data line is released at the end of the START/STOP, exactly `BUF_US` microseconds pass before `done`.
- R7: On a successful recovery, `rest_warn`=1 if either line read low at the last sample. On a failed recovery, `rest_warn`=0.
- R8: If the clock line is held low by a slave after release, the sequencer waits at most `STRETCH_US` microseconds and then proceeds as if it had risen.
- R9: `done` is a one-cycle pulse, `busy` falls on the same edge that raises it, and `ok` and `rest_warn` are valid with it and held until the next request.
- R10: A request that arrives while `busy`=1 is ignored: the run in progress keeps its pulse count and gives a single `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Start a recovery (sampled only while idle) |
| scl_in | input | 1 | Wired level of the clock line |
| sda_in | input | 1 | Wired level of the data line |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |
| busy | output | 1 | Recovery in progress |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Data line was seen high (valid with done) |
| rest_warn | output | 1 | Lines not both high at the end of clocking |

## Verification
The embedded properties hold on every cycle. They check that the data line is never pulled low while the clock line is pulled low, that the data line is only pulled after the clock has been released for at least a cycle, that `done` lasts one cycle and coincides with `busy` falling, that a failed run never carries a warning, and that no clock phase starts beyond the pulse budget. Only the scenarios can show the rest. Those depend on a modelled slave: which sample patterns give success, failure or a warning, the exact phase widths, the bus-free gap, the stretch timeout under a clock held low, and that a second request during a run changes nothing.

// File: rtl/twi_recover.sv
module twi_recover #(
  parameter int CLK_PER_US = 50,
  parameter int PULSES     = 9,
  parameter int LOW_US     = 2,
  parameter int HIGH_US    = 2,
  parameter int STRETCH_US = 1000,
  parameter int SETUP_US   = 1,
  parameter int SDA_LOW_US = 1,
  parameter int BUF_US     = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_oe,
  output logic sda_oe,
  output logic busy,
  output logic done,
  output logic ok,
  output logic rest_warn
);

  localparam int LOW_N  = LOW_US * CLK_PER_US;
  localparam int HIGH_N = HIGH_US * CLK_PER_US;
  localparam int STR_N  = STRETCH_US * CLK_PER_US;
  localparam int SET_N  = SETUP_US * CLK_PER_US;
  localparam int SLO_N  = SDA_LOW_US * CLK_PER_US;
  localparam int BUF_N  = BUF_US * CLK_PER_US;
  localparam int MAX_N  = (STR_N > BUF_N) ? STR_N : BUF_N;
  localparam int TW     = $clog2(MAX_N + 2);
  localparam int PW     = $clog2(PULSES + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_LOW, S_RISE, S_HIGH, S_SETUP, S_SDALO, S_BUF
  } st_t;

  st_t           state, nxt;
  logic [TW-1:0] tcnt;
  logic [PW-1:0] pcnt;
  logic          seen;

  function automatic logic at_end(input int n);
    return tcnt == TW'(n - 1);
  endfunction

  wire last_pulse = (pcnt == PW'(PULSES - 1));
  wire sda_hit    = seen | sda_in;

  assign scl_oe = (state == S_LOW);
  assign sda_oe = (state == S_SDALO);
  assign busy   = (state != S_IDLE);

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:  if (req) nxt = S_LOW;
      S_LOW:   if (at_end(LOW_N)) nxt = S_RISE;
      S_RISE:  if (scl_in || at_end(STR_N)) nxt = S_HIGH;
      S_HIGH:  if (at_end(HIGH_N))
                 nxt = !last_pulse ? S_LOW : (sda_hit ? S_SETUP : S_IDLE);
      S_SETUP: if (at_end(SET_N)) nxt = S_SDALO;
      S_SDALO: if (at_end(SLO_N)) nxt = S_BUF;
      S_BUF:   if (at_end(BUF_N)) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      tcnt      <= '0;
      pcnt      <= '0;
      seen      <= 1'b0;
      done      <= 1'b0;
      ok        <= 1'b0;
      rest_warn <= 1'b0;
    end else begin
      state <= nxt;
      tcnt  <= (nxt != state) ? '0 : tcnt + 1'b1;
      done  <= 1'b0;
      if (state == S_IDLE && req) begin
        pcnt      <= '0;
        seen      <= 1'b0;
        ok        <= 1'b0;
        rest_warn <= 1'b0;
      end
      if (state == S_HIGH && at_end(HIGH_N)) begin
        seen <= sda_hit;
        pcnt <= pcnt + 1'b1;
        if (last_pulse) begin
          rest_warn <= sda_hit & ~(scl_in & sda_in);
          if (!sda_hit) done <= 1'b1;
        end
      end
      if (state == S_BUF && at_end(BUF_N)) begin
        done <= 1'b1;
        ok   <= 1'b1;
      end
    end
  end

  // R5
  sda_scl_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> !scl_oe);

  // R5
  sda_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(!scl_oe));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R7
  fail_nowarn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ok) |-> !rest_warn);

  // R2
  pulse_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> (pcnt < PW'(PULSES)));

endmodule

// File: tb/twi_recover_bench.sv
module twi_recover_bench;
  localparam int P   = 50;
  localparam int STR = 20;

  logic clk = 0, rst_n = 0, req = 0;
  logic scl_hold = 0;
  logic [9:0] pat = '0;
  int   pidx = 0;
  wire  scl_oe, sda_oe, busy, done, ok, rest_warn;
  wire  scl_in = !(scl_oe || scl_hold);
  wire  sda_in = !(sda_oe || pat[pidx]);

  int checks = 0, fails = 0;
  int cyc = 0, scl_rises = 0, sda_rises = 0, dones = 0, viol = 0;
  int scl_t0 = 0, scl_w = 0, sda_t0 = 0, sda_w = 0, sda_fall = 0, gap = 0;
  logic prev_scl = 0, prev_sda = 0, mon_clr = 0;

  always #10 clk = ~clk;

  twi_recover #(.CLK_PER_US(P), .STRETCH_US(STR)) u_twi_recover (
    .clk(clk), .rst_n(rst_n), .req(req), .scl_in(scl_in), .sda_in(sda_in),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done), .ok(ok),
    .rest_warn(rest_warn));

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (mon_clr) begin
      scl_rises <= 0; sda_rises <= 0; dones <= 0; viol <= 0; pidx <= 0;
      gap <= -1; sda_w <= -1; scl_w <= -1;
    end else begin
      if (!prev_scl && scl_oe) begin
        scl_rises <= scl_rises + 1; scl_t0 <= cyc;
        if (pidx < 9) pidx <= pidx + 1;
      end
      if (prev_scl && !scl_oe) scl_w <= cyc - scl_t0;
      if (!prev_sda && sda_oe) begin sda_rises <= sda_rises + 1; sda_t0 <= cyc; end
      if (prev_sda && !sda_oe) begin sda_w <= cyc - sda_t0; sda_fall <= cyc; end
      if (sda_oe && scl_oe) viol <= viol + 1;
      if (done) begin dones <= dones + 1; gap <= cyc - sda_fall; end
    end
    prev_scl <= scl_oe;
    prev_sda <= sda_oe;
  end

  task automatic chk(input bit c, input string tag, input int act, input int exp);
    checks++;
    if (!c) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input logic [9:0] p, input bit hold, input bit extra_req,
                     output bit r_ok, output bit r_warn, output int elapsed);
    int t0;
    @(negedge clk);
    pat = p; scl_hold = hold; mon_clr = 1;
    @(negedge clk);
    mon_clr = 0; req = 1; t0 = cyc;
    @(negedge clk);
    req = 0;
    if (extra_req) begin
      repeat (600) @(negedge clk);
      req = 1;
      @(negedge clk);
      req = 0;
    end
    while (!done) @(negedge clk);
    r_ok = ok; r_warn = rest_warn; elapsed = cyc - t0;
    @(negedge clk);
    chk(!done, "R9 done one cycle", done, 0);
    chk(ok == r_ok && rest_warn == r_warn, "R9 results held", ok, r_ok);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!scl_oe && !sda_oe, "R1 lines released", {scl_oe, sda_oe}, 0);
    chk(!busy && !done, "R1 idle", {busy, done}, 0);
  endtask

  task automatic t_clean();
    bit o, w; int e;
    run('0, 0, 0, o, w, e);
    chk(scl_rises == 9, "R2 nine pulses clean", scl_rises, 9);
    chk(scl_w == 2 * P, "R3 low phase width", scl_w, 2 * P);
    chk(o == 1, "R4 ok on clean bus", o, 1);
    chk(w == 0, "R7 no warn clean", w, 0);
    chk(sda_rises == 1, "R5 one sda pulse", sda_rises, 1);
    chk(sda_w == P, "R5 sda low width", sda_w, P);
    chk(viol == 0, "R5 scl released during sda low", viol, 0);
    chk(gap == 60 * P, "R6 bus free gap", gap, 60 * P);
    chk(dones == 1, "R9 single done", dones, 1);
    chk(e == 9 * (4 * P + 1) + 2 * P + 60 * P + 1, "R3 total duration", e,
        9 * (4 * P + 1) + 2 * P + 60 * P + 1);
  endtask

  task automatic t_stuck();
    bit o, w; int e;
    run(10'b11_1111_1110, 0, 0, o, w, e);
    chk(o == 0, "R4 fail when never high", o, 0);
    chk(w == 0, "R7 no warn on fail", w, 0);
    chk(sda_rises == 0, "R4 no start/stop on fail", sda_rises, 0);
    chk(scl_rises == 9, "R2 nine pulses stuck", scl_rises, 9);
  endtask

  task automatic t_late();
    bit o, w; int e;
    run(10'b01_1111_1110, 0, 0, o, w, e);
    chk(o == 1, "R4 ok when high only at last sample", o, 1);
    chk(w == 0, "R7 no warn late release", w, 0);
  endtask

  task automatic t_glitch();
    bit o, w; int e;
    run(10'b11_1111_0110, 0, 0, o, w, e);
    chk(scl_rises == 9, "R2 clocking continues after high seen", scl_rises, 9);
    chk(o == 1, "R4 ok early high", o, 1);
    chk(w == 1, "R7 warn sda low at end", w, 1);
    chk(sda_rises == 1, "R5 start/stop after glitch", sda_rises, 1);
  endtask

  task automatic t_busy_req();
    bit o, w; int e;
    run('0, 0, 1, o, w, e);
    chk(scl_rises == 9, "R10 pulses unchanged", scl_rises, 9);
    chk(dones == 1, "R10 single done", dones, 1);
    repeat (200) @(negedge clk);
    chk(!busy, "R10 no restart", busy, 0);
  endtask

  task automatic t_stretch();
    bit o, w; int e;
    run('0, 1, 0, o, w, e);
    chk(e >= 9 * STR * P, "R8 stretch timeout waited", e, 9 * STR * P);
    chk(scl_rises == 9, "R8 proceeds after timeout", scl_rises, 9);
    chk(o == 1 && w == 1, "R8 warn scl low", {o, w}, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_clean();
    t_stuck();
    t_late();
    t_glitch();
    t_busy_req();
    t_stretch();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule